// File: doc/BRIEF.md
# Bitstream Container Header Stripper

This block sits in the path between storage that holds a configuration container file and the logic that loads a programmable device. Bytes of the file arrive one per handshake. Everything up to and including a marker byte of value 0x65 is thrown away. The four bytes after the marker give the payload size in bytes, with the most significant byte first. The block then passes exactly that many bytes to its output and discards the rest. Multiplying the decoded size by eight gives the number of configuration bits the loader must clock out.

The payload goes through without a buffer. In the payload phase the input handshake is tied to the output handshake, so backpressure from the loader reaches the source directly. In every other phase the block consumes input freely. The decoded size is held on its own port after the header has been read. A sticky error flag goes high if the source marks its final byte before the marker, the size field or the full payload has arrived.

Top module: `bitstream_hdr_strip`

## Requirements
- R1: After a synchronous reset, inReady is 1 and outValid, lenValid, truncErr, done are 0 and payloadLen is 0.
- R2: Every byte accepted before the first 0x65 byte is dropped, so outValid stays 0.
- R3: The four bytes accepted after the marker form payloadLen, with the first of them in bits 31:24 and the last in bits 7:0. lenValid rises together with payloadLen once the fourth byte is taken.
- R4: In the payload phase, outValid equals inValid, and each payload byte appears on outData unchanged and in arrival order.
- R5: outLast is 1 on the payload byte whose number equals payloadLen and is 0 on every earlier byte. Once that byte is transferred, done goes to 1.
- R6: A 0x65 byte inside the payload is forwarded as data and does not restart header decoding.
- R7: Once done is 1, input bytes are still accepted (inReady is 1) but produce no output. An inLast arriving then raises no error.
- R8: A size field of zero sets done directly after the fourth size byte and produces no output byte.
- R9: An accepted byte with inLast set, seen in the scan phase or before the fourth size byte is taken, sets truncErr and done. inLast on the fourth size byte does the same unless the size is zero.
- R10: inLast on a payload byte before the final one sets truncErr and done. truncErr stays at 1 until reset.
- R11: In the payload phase inReady equals outReady. In all other phases inReady is 1.
- R12: A reset applied in the middle of a stream returns the block to the scan phase and clears payloadLen and lenValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Source byte valid |
| inData | input | 8 | Source byte |
| inLast | input | 1 | Source byte is the final byte of the file |
| inReady | output | 1 | Block accepts the source byte |
| outValid | output | 1 | Payload byte valid |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Final payload byte |
| outReady | input | 1 | Loader accepts the payload byte |
| payloadLen | output | 32 | Decoded payload size in bytes |
| lenValid | output | 1 | payloadLen holds a complete size |
| truncErr | output | 1 | Input ended early (sticky) |
| done | output | 1 | Payload finished or stream aborted |

## Verification
The bench uses a size field with four distinct bytes. A design that assembled the size little-endian, or shifted it the wrong way, would report a reversed value. It also places a marker byte inside the payload, which a design that kept hunting for the marker would treat as a new header. Zero-length and premature-end streams are run to show that a size of zero ends the payload at once instead of wrapping the counter, and that an early end sets the sticky error. The backpressure stall and the reset in the middle of the size field show that no payload byte is lost while stalled and that no partial size survives a reset.

// File: rtl/hdr_strip_pkg.sv
package hdr_strip_pkg;
  typedef enum logic [2:0] {
    ST_SCAN,
    ST_LEN0,
    ST_LEN1,
    ST_LEN2,
    ST_LEN3,
    ST_PAYLOAD,
    ST_DONE
  } parseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftLen;
    logic loadCount;
    logic decCount;
  } dpCtrl_t;
endpackage

// File: rtl/hdr_strip_dp.sv
module hdr_strip_dp
  import hdr_strip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] inData,
  output logic [LEN_W-1:0]  payloadLen,
  output logic              lenNextZero,
  output logic              remainOne
);
  localparam int KEEP_W = LEN_W - DATA_W;

  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] lenNext;
  logic [LEN_W-1:0] remaining;

  // the newest byte enters at the bottom, so the first byte ends up on top
  assign lenNext     = {lenReg[KEEP_W-1:0], inData};
  assign lenNextZero = (lenNext == '0);
  assign remainOne   = (remaining == LEN_W'(1));
  assign payloadLen  = lenReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg <= '0;
    end else if (ctrl.shiftLen) begin
      lenReg <= lenNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (ctrl.loadCount) begin
      remaining <= lenNext;
    end else if (ctrl.decCount) begin
      remaining <= remaining - LEN_W'(1);
    end
  end
endmodule

// File: rtl/hdr_strip_ctrl.sv
module hdr_strip_ctrl
  import hdr_strip_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  KEY_VAL = 8'h65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  input  logic              lenNextZero,
  input  logic              remainOne,
  output dpCtrl_t           ctrl,
  output logic              inReady,
  output logic              outValid,
  output logic              outLast,
  output logic              lenValid,
  output logic              truncErr,
  output logic              done
);
  parseState_t state, nextState;
  logic accept;
  logic setErr;
  logic setLenValid;
  logic isKey;

  assign isKey    = (inData == DATA_W'(KEY_VAL));
  assign inReady  = (state == ST_PAYLOAD) ? outReady : 1'b1;
  assign accept   = inValid && inReady;
  assign outValid = (state == ST_PAYLOAD) && inValid;
  assign outLast  = outValid && remainOne;
  assign done     = (state == ST_DONE);

  always_comb begin
    nextState   = state;
    ctrl        = '0;
    setErr      = 1'b0;
    setLenValid = 1'b0;
    unique case (state)
      ST_SCAN: begin
        if (accept) begin
          if (inLast) begin
            nextState = ST_DONE;
            setErr    = 1'b1;
          end else if (isKey) begin
            nextState = ST_LEN0;
          end
        end
      end
      ST_LEN0, ST_LEN1, ST_LEN2: begin
        if (accept) begin
          ctrl.shiftLen = 1'b1;
          if (inLast) begin
            nextState = ST_DONE;
            setErr    = 1'b1;
          end else begin
            nextState = parseState_t'(state + 3'd1);
          end
        end
      end
      ST_LEN3: begin
        if (accept) begin
          ctrl.shiftLen  = 1'b1;
          ctrl.loadCount = 1'b1;
          setLenValid    = 1'b1;
          if (lenNextZero) begin
            nextState = ST_DONE;
          end else if (inLast) begin
            nextState = ST_DONE;
            setErr    = 1'b1;
          end else begin
            nextState = ST_PAYLOAD;
          end
        end
      end
      ST_PAYLOAD: begin
        if (accept) begin
          ctrl.decCount = 1'b1;
          if (remainOne) begin
            nextState = ST_DONE;
          end else if (inLast) begin
            nextState = ST_DONE;
            setErr    = 1'b1;
          end
        end
      end
      ST_DONE: nextState = ST_DONE;
      default: nextState = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SCAN;
      lenValid <= 1'b0;
      truncErr <= 1'b0;
    end else begin
      state <= nextState;
      if (setLenValid) lenValid <= 1'b1;
      if (setErr)      truncErr <= 1'b1;
    end
  end
endmodule

// File: rtl/bitstream_hdr_strip.sv
module bitstream_hdr_strip
  import hdr_strip_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter int         LEN_W   = 32,
  parameter logic [7:0] KEY_VAL = 8'h65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  input  logic              outReady,
  output logic [LEN_W-1:0]  payloadLen,
  output logic              lenValid,
  output logic              truncErr,
  output logic              done
);
  dpCtrl_t ctrl;
  logic lenNextZero;
  logic remainOne;

  assign outData = inData;

  hdr_strip_ctrl #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .inData(inData),
    .outReady(outReady), .lenNextZero(lenNextZero), .remainOne(remainOne),
    .ctrl(ctrl), .inReady(inReady), .outValid(outValid), .outLast(outLast),
    .lenValid(lenValid), .truncErr(truncErr), .done(done)
  );

  hdr_strip_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .inData(inData),
    .payloadLen(payloadLen), .lenNextZero(lenNextZero), .remainOne(remainOne)
  );
endmodule

// File: rtl/hdr_strip_chk.sv
module hdr_strip_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic             outLast,
  input logic [LEN_W-1:0] payloadLen,
  input logic             lenValid,
  input logic             truncErr,
  input logic             done
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!lenValid && !truncErr && !done && payloadLen == '0));

  // R11
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!outValid && inReady));

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast) |=> done);

  // R3
  len_stable_chk: assert property (@(posedge clk) disable iff (rst)
    lenValid |=> (lenValid && $stable(payloadLen)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    truncErr |=> (truncErr && done));
endmodule

bind bitstream_hdr_strip hdr_strip_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outLast(outLast), .payloadLen(payloadLen),
  .lenValid(lenValid), .truncErr(truncErr), .done(done)
);

// File: tb/tb_bitstream_hdr_strip.sv
`timescale 1ns/1ps
module tb_bitstream_hdr_strip;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;
  logic outReady = 1'b1;
  logic inReady, outValid, outLast, lenValid, truncErr, done;
  logic [7:0] outData;
  logic [31:0] payloadLen;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bitstream_hdr_strip dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outLast(outLast),
    .outReady(outReady), .payloadLen(payloadLen), .lenValid(lenValid),
    .truncErr(truncErr), .done(done)
  );

  // vector: {byte, inLast, expected outValid, expected outLast}
  localparam int NVEC = 11;
  localparam logic [10:0] VECS [NVEC] = '{
    {8'h11, 1'b0, 1'b0, 1'b0},  // R2 dropped
    {8'h22, 1'b0, 1'b0, 1'b0},  // R2 dropped
    {8'h65, 1'b0, 1'b0, 1'b0},  // marker
    {8'h00, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0},
    {8'h03, 1'b0, 1'b0, 1'b0},  // size 3
    {8'hA5, 1'b0, 1'b1, 1'b0},  // R4
    {8'h65, 1'b0, 1'b1, 1'b0},  // R6 marker as data
    {8'h3C, 1'b0, 1'b1, 1'b1},  // R5 final
    {8'h77, 1'b1, 1'b0, 1'b0}   // R7 dropped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    inLast = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic l, input logic expV,
                      input logic expL, input string req);
    @(negedge clk);
    inValid = 1'b1;
    inData = d;
    inLast = l;
    #1;
    chk({req, " outValid"}, 32'(outValid), 32'(expV));
    if (expV) begin
      chk({req, " outData"}, 32'(outData), 32'(d));
      chk({req, " outLast"}, 32'(outLast), 32'(expL));
    end
    @(posedge clk);
    #1 inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic header(input logic [31:0] len);
    push(8'h65, 1'b0, 1'b0, 1'b0, "R2");
    for (int k = 3; k >= 0; k--) push(len[k*8 +: 8], 1'b0, 1'b0, 1'b0, "R3");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    chk("R1 inReady", 32'(inReady), 32'd1);
    chk("R1 lenValid", 32'(lenValid), 32'd0);
    chk("R1 truncErr", 32'(truncErr), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 payloadLen", payloadLen, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      push(VECS[i][10:3], VECS[i][2], VECS[i][1], VECS[i][0], "R4/R5/R6 vector");
    end
    chk("R3 payloadLen", payloadLen, 32'd3);
    chk("R3 lenValid", 32'(lenValid), 32'd1);
    chk("R7 done", 32'(done), 32'd1);
    chk("R7 no error", 32'(truncErr), 32'd0);
    push(8'h5A, 1'b0, 1'b0, 1'b0, "R7 after done");
    chk("R7 inReady", 32'(inReady), 32'd1);

    // R3 byte order
    doReset();
    header(32'h01020304);
    chk("R3 big-endian", payloadLen, 32'h01020304);
    chk("R3 lenValid", 32'(lenValid), 32'd1);

    // R8 zero size
    doReset();
    header(32'h0);
    chk("R8 done", 32'(done), 32'd1);
    push(8'h99, 1'b0, 1'b0, 1'b0, "R8 no output");
    chk("R8 no error", 32'(truncErr), 32'd0);

    // R9 end inside size field
    doReset();
    push(8'h65, 1'b0, 1'b0, 1'b0, "R9");
    push(8'h00, 1'b0, 1'b0, 1'b0, "R9");
    push(8'h00, 1'b1, 1'b0, 1'b0, "R9");
    chk("R9 truncErr", 32'(truncErr), 32'd1);
    chk("R9 done", 32'(done), 32'd1);
    chk("R9 lenValid", 32'(lenValid), 32'd0);

    // R9 end before marker
    doReset();
    push(8'h10, 1'b1, 1'b0, 1'b0, "R9 scan");
    chk("R9 scan truncErr", 32'(truncErr), 32'd1);

    // R10 end inside payload
    doReset();
    header(32'd5);
    push(8'hAA, 1'b0, 1'b1, 1'b0, "R10");
    push(8'hBB, 1'b1, 1'b1, 1'b0, "R10");
    chk("R10 truncErr", 32'(truncErr), 32'd1);
    chk("R10 done", 32'(done), 32'd1);
    push(8'hCC, 1'b0, 1'b0, 1'b0, "R10 after");
    chk("R10 sticky", 32'(truncErr), 32'd1);

    // R11 backpressure
    doReset();
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1'b1;
    inData = 8'h10;
    #1 chk("R11 scan ready", 32'(inReady), 32'd1);
    outReady = 1'b1;
    inValid = 1'b0;
    header(32'd2);
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1'b1;
    inData = 8'hC1;
    #1;
    chk("R11 stalled inReady", 32'(inReady), 32'd0);
    chk("R11 stalled outValid", 32'(outValid), 32'd1);
    @(negedge clk);
    #1;
    chk("R11 held data", 32'(outData), 32'hC1);
    chk("R11 held not last", 32'(outLast), 32'd0);
    outReady = 1'b1;
    #1 chk("R11 released inReady", 32'(inReady), 32'd1);
    @(posedge clk);
    #1 inValid = 1'b0;
    push(8'hC2, 1'b0, 1'b1, 1'b1, "R11 second byte");
    chk("R11 done", 32'(done), 32'd1);

    // R12 reset mid-size
    doReset();
    push(8'h65, 1'b0, 1'b0, 1'b0, "R12");
    push(8'h01, 1'b0, 1'b0, 1'b0, "R12");
    push(8'h02, 1'b0, 1'b0, 1'b0, "R12");
    doReset();
    chk("R12 payloadLen", payloadLen, 32'd0);
    chk("R12 lenValid", 32'(lenValid), 32'd0);
    push(8'h00, 1'b0, 1'b0, 1'b0, "R12 scan");
    push(8'h01, 1'b0, 1'b0, 1'b0, "R12 scan");
    push(8'hEE, 1'b0, 1'b0, 1'b0, "R12 scan");
    header(32'd1);
    push(8'hEE, 1'b0, 1'b1, 1'b1, "R12 fresh payload");
    chk("R12 payloadLen new", payloadLen, 32'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule